// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block watches an I2C bus from the target side and decides whether the transfer now starting is meant for it. A fast system clock oversamples SCL and SDA. The block finds START and STOP conditions and shifts in address bytes MSB first on rising SCL edges. When a byte is accepted, it pulls SDA low through an open-drain enable for the acknowledge clock. Two configuration registers set what it answers to. The own-address register holds a 7-bit address in bits [7:1] and a general-call enable in bit 0. The extension register holds the low eight bits of a 10-bit address.

The own-address register selects the addressing scheme. If its bits [7:3] equal 11110b, the block works with 10-bit addresses. Bits [2:1] of the register then become address bits 9:8, and the extension register supplies address bits 7:0. In 10-bit mode the header byte is acknowledged quietly. The interrupt pulse and the slave-mode flag appear only after the second byte also matches. The block remembers a completed 10-bit write addressing until the next STOP, so a repeated START with the read header is enough to re-enter slave mode for reading.

The block carries no data stream: all pins are plain control or status. Data bytes after the address phase, clock stretching and controller mode belong to other logic.

Top module: `i2c_target_addr_match`

## Requirements
- R1: After reset, irq, slave_mode, dir_read and sda_pull are all 0.
- R2: In 7-bit mode (own_addr[7:3] not 11110b), a first byte whose bits [7:1] equal own_addr[7:1] (and are not all zero) is acknowledged. The block then raises irq, sets slave_mode, and reports bit 0 of that byte on dir_read (1 = read).
- R3: A first byte that does not match is not acknowledged (SDA stays released) and gives no irq. Later bytes are then ignored until the next START.
- R4: The byte 00h is acknowledged with irq, slave_mode = 1 and dir_read = 0 when own_addr[0] is 1. It is ignored when own_addr[0] is 0.
- R5: 10-bit mode is in effect when own_addr[7:3] = 11110b. A header byte whose bits [2:1] differ from own_addr[2:1] is not acknowledged.
- R6: In 10-bit mode, the write header {11110b, own_addr[2:1], 0} is acknowledged without irq and without setting slave_mode.
- R7: A second byte equal to ext_addr after that header is acknowledged and raises irq with slave_mode = 1 and dir_read = 0. Any other second byte is not acknowledged and gives no irq.
- R8: After a completed 10-bit write addressing, a repeated START followed by the read header {11110b, own_addr[2:1], 1} is acknowledged with irq, slave_mode = 1 and dir_read = 1.
- R9: A STOP clears slave_mode and releases SDA. It also clears the remembered 10-bit match, so a later read header alone is not acknowledged.
- R10: A START, including a repeated START, clears slave_mode.
- R11: irq is high for exactly one system clock per accepted address.
- R12: sda_pull is 0 while SCL is high during the eighth address bit. It rises only while SCL is low and is released after the falling edge of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| own_addr | input | 8 | Own address [7:1], general-call enable [0] |
| ext_addr | input | 8 | Low eight bits of the 10-bit address |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| irq | output | 1 | One-clock pulse when addressing completes |
| slave_mode | output | 1 | Set while addressed, until STOP or START |
| dir_read | output | 1 | Direction of the accepted transfer, 1 = read |

## Verification
The bench uses an own-address value that would match as a 7-bit address if 10-bit mode were not detected. A design that misses the 11110b prefix therefore raises an interrupt on the header byte, which the bench catches. It also runs a repeated read header after a STOP to show that the remembered 10-bit match is cleared; a design that keeps it acknowledges that header wrongly. The bench sends a matching byte without a START after a mismatch, so a design that keeps shifting after a NAK would acknowledge it. General call is tried with the enable both off and on, and the acknowledge window is probed on the eighth bit and after the ninth clock, where an early or late pull would show.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_HOLD} am_state_e;

  typedef struct packed {
    logic ack;       // acknowledge this byte
    logic final_m;   // addressing complete after this byte
    logic dir;       // reported direction when final
    logic remember;  // set the 10-bit write memory
    logic forget;    // clear the 10-bit write memory
  } am_verdict_t;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, cur, prv;
  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw[g]};
    end
    assign cur[g] = pipe[STAGES-1];
    assign prv[g] = pipe[STAGES];
  end

  assign scl_s     = cur[0];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         full
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
    end else if (clear) begin
      cnt  <= '0;
      data <= '0;
    end else if (sample && !full) begin
      data <= {data[W-2:0], bit_in};
      cnt  <= cnt + 1'b1;
    end
  end

  // R2: bits enter MSB first, newest bit at position 0
  a_r2_bit_lands_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !full && !clear) |=> data[0] == $past(bit_in));
endmodule

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
  import i2c_am_pkg::*;
(
  input  logic [7:0]  rx_byte,
  input  logic        second,
  input  logic        remembered,
  input  logic [7:0]  own_addr,
  input  logic [7:0]  ext_addr,
  output am_verdict_t verdict
);
  logic ten_mode, gc_hit, hdr_hit, hit7;

  assign ten_mode = (own_addr[7:3] == TEN_PREFIX);
  assign gc_hit   = own_addr[0] && (rx_byte == 8'h00);
  assign hdr_hit  = (rx_byte[7:1] == {TEN_PREFIX, own_addr[2:1]});
  assign hit7     = (rx_byte[7:1] == own_addr[7:1]) && (rx_byte[7:1] != 7'd0);

  always_comb begin
    verdict = '0;
    if (second) begin
      if (rx_byte == ext_addr) begin
        verdict.ack      = 1'b1;
        verdict.final_m  = 1'b1;
        verdict.remember = 1'b1;
      end else begin
        verdict.forget = 1'b1;
      end
    end else if (gc_hit) begin
      verdict.ack     = 1'b1;
      verdict.final_m = 1'b1;
    end else if (!ten_mode) begin
      if (hit7) begin
        verdict.ack     = 1'b1;
        verdict.final_m = 1'b1;
        verdict.dir     = rx_byte[0];
      end
    end else if (hdr_hit && !rx_byte[0]) begin
      verdict.ack = 1'b1;
    end else if (hdr_hit && remembered) begin
      verdict.ack     = 1'b1;
      verdict.final_m = 1'b1;
      verdict.dir     = 1'b1;
    end
  end
endmodule

// File: rtl/i2c_target_addr_match.sv
module i2c_target_addr_match
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              sda_pull,
  output logic              irq,
  output logic              slave_mode,
  output logic              dir_read
);
  logic scl_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] rx_byte;
  logic byte_full, shift_clear, shift_sample;
  logic second, remembered, go_second;
  am_state_e   st;
  am_verdict_t v;

  i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign shift_clear  = start_det | stop_det | ((st == ST_ACK) & scl_fall);
  assign shift_sample = scl_rise & (st == ST_RX);

  i2c_am_shift #(.W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(shift_clear), .sample(shift_sample),
    .bit_in(sda_in_s()), .data(rx_byte), .full(byte_full)
  );

  i2c_am_decode u_dec (
    .rx_byte(rx_byte), .second(second), .remembered(remembered),
    .own_addr(own_addr), .ext_addr(ext_addr), .verdict(v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      second     <= 1'b0;
      remembered <= 1'b0;
      go_second  <= 1'b0;
      sda_pull   <= 1'b0;
      irq        <= 1'b0;
      slave_mode <= 1'b0;
      dir_read   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop_det) begin
        st         <= ST_IDLE;
        sda_pull   <= 1'b0;
        slave_mode <= 1'b0;
        remembered <= 1'b0;
      end else if (start_det) begin
        st         <= ST_RX;
        second     <= 1'b0;
        sda_pull   <= 1'b0;
        slave_mode <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_fall && byte_full) begin
            if (v.ack) begin
              st        <= ST_ACK;
              sda_pull  <= 1'b1;
              go_second <= !v.final_m;
              if (v.final_m) begin
                irq        <= 1'b1;
                slave_mode <= 1'b1;
                dir_read   <= v.dir;
              end
            end else begin
              st <= ST_IDLE;
            end
            if (v.remember)    remembered <= 1'b1;
            else if (v.forget) remembered <= 1'b0;
          end
          ST_ACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            if (go_second) begin
              st     <= ST_RX;
              second <= 1'b1;
            end else begin
              st <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // synchronized SDA for the shifter, same latency as SCL edges
  function automatic logic sda_in_s();
    return u_sync.cur[1];
  endfunction

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r2_slave_enters_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_mode) |-> irq);
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!slave_mode && !sda_pull));
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !slave_mode);
  a_r12_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
endmodule

// File: tb/test_i2c_target_addr_match.sv
module test_i2c_target_addr_match;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] own_addr = 8'h00, ext_addr = 8'h00;
  logic sda_pull, irq, slave_mode, dir_read;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_P/2) clk = ~clk;

  i2c_target_addr_match i_i2c_target_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .own_addr(own_addr), .ext_addr(ext_addr), .sda_pull(sda_pull),
    .irq(irq), .slave_mode(slave_mode), .dir_read(dir_read)
  );

  int total = 0, bad = 0, irq_seen = 0;
  bit exp_q[$];
  logic irq_prev = 1'b0;
  logic oe_bit8 = 1'b0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic bus_rstart();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic bus_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q();
      if (i == 0) oe_bit8 = sda_pull;
      q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q(); acked = !sda_line; q(); scl_m = 0; q();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (irq) begin
      irq_seen++;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected irq actual=1 expected=0");
      end else begin
        bit e;
        e = exp_q.pop_front();
        check("R2", "dir_read at irq", dir_read, e);
        check("R2", "slave_mode at irq", slave_mode, 1);
      end
      if (irq_prev) check("R11", "irq width", 2, 1);
    end
    irq_prev = irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    int n0;
    repeat (5) @(negedge clk);
    check("R1", "irq", irq, 0);
    check("R1", "slave_mode", slave_mode, 0);
    check("R1", "sda_pull", sda_pull, 0);
    check("R1", "dir_read", dir_read, 0);
    rst_n = 1; repeat (5) @(negedge clk);

    // 7-bit read
    own_addr = 8'hA4;
    bus_start(); exp_q.push_back(1'b1); send_byte(8'hA5, a);
    check("R2", "ack 7-bit read", a, 1);
    check("R12", "pull during bit 8", oe_bit8, 0);
    repeat (6) @(negedge clk);
    check("R12", "pull after ninth clock", sda_pull, 0);
    check("R2", "slave_mode held", slave_mode, 1);
    check("R2", "irq missing", exp_q.size(), 0);
    bus_stop();
    check("R9", "slave_mode after stop", slave_mode, 0);

    // 7-bit write, then repeated start clears
    bus_start(); exp_q.push_back(1'b0); send_byte(8'hA4, a);
    check("R2", "ack 7-bit write", a, 1);
    check("R2", "slave_mode", slave_mode, 1);
    bus_rstart();
    check("R10", "slave_mode after rstart", slave_mode, 0);
    send_byte(8'h10, a);
    check("R3", "nak other address", a, 0);
    bus_stop();

    // mismatch then match without start
    bus_start(); n0 = irq_seen; send_byte(8'hB4, a);
    check("R3", "nak mismatch", a, 0);
    send_byte(8'hA4, a);
    check("R3", "ignored until start", a, 0);
    check("R3", "no irq", irq_seen, n0);
    check("R3", "slave_mode", slave_mode, 0);
    bus_stop();

    // general call
    bus_start(); send_byte(8'h00, a);
    check("R4", "gc disabled nak", a, 0);
    bus_stop();
    own_addr = 8'hA5;
    bus_start(); exp_q.push_back(1'b0); send_byte(8'h00, a);
    check("R4", "gc enabled ack", a, 1);
    check("R4", "slave_mode", slave_mode, 1);
    bus_stop();

    // 10-bit
    own_addr = 8'hF2; ext_addr = 8'h3C;
    bus_start(); n0 = irq_seen; send_byte(8'hF2, a);
    check("R6", "header ack", a, 1);
    repeat (6) @(negedge clk);
    check("R6", "no irq on header", irq_seen, n0);
    check("R5", "no slave_mode on header", slave_mode, 0);
    exp_q.push_back(1'b0); send_byte(8'h3C, a);
    check("R7", "second byte ack", a, 1);
    check("R7", "slave_mode", slave_mode, 1);
    bus_rstart();
    check("R10", "slave_mode after rstart", slave_mode, 0);
    exp_q.push_back(1'b1); send_byte(8'hF3, a);
    check("R8", "read header ack", a, 1);
    check("R8", "dir_read", dir_read, 1);
    bus_stop();

    bus_start(); send_byte(8'hF3, a);
    check("R9", "memory cleared by stop", a, 0);
    bus_stop();

    bus_start(); send_byte(8'hF2, a);
    check("R6", "header ack again", a, 1);
    n0 = irq_seen; send_byte(8'h3D, a);
    check("R7", "wrong second byte nak", a, 0);
    check("R7", "no irq", irq_seen, n0);
    bus_stop();

    bus_start(); send_byte(8'hF4, a);
    check("R5", "wrong upper bits nak", a, 0);
    bus_stop();

    repeat (10) @(negedge clk);
    check("R2", "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule